// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

This block is a 32-bit down-counter driven from a single clock through an 8-bit prescaler. Software programs a start value, chooses one-shot or periodic operation and a clock divisor, and then enables the timer. The count drops by one on every prescaled tick. When it runs out, a sticky event flag is raised. In periodic mode the count is refilled from the stored start value and keeps running. In one-shot mode it parks at zero. The event flag drives a level interrupt line directly, and software clears it by writing a one.

Access uses a plain single-cycle register port. A request is presented for one clock with a write flag, a word address, byte enables and write data. A read returns its data one clock later, qualified by a valid strobe. Four word registers are decoded: start value, live count, control and event flag. A write to the start-value register also restarts the countdown from the written value.

Top module: `ptmr_top`

## Requirements
- R1: After reset, the start value, the count, the control bits and the event flag are all zero, and `irq_o` is low.
- R2: Word offsets are 0x0 (start value), 0x4 (count), 0x8 (control) and 0xC (event flag). A read returns `rd_valid` high with its data one clock after the request. A read of any other offset, or of an address with either low bit set, returns zero. A write is ignored if it targets such an address or if its byte enables are not all ones.
- R3: In the control register, bit 0 enables counting, bit 1 selects periodic reload and bits 15:8 hold the divisor P. The other control bits read back as zero.
- R4: While enabled with a non-zero count, the count falls by one every P+1 clocks. The first step lands P+1 clocks after the enabling write or after any write to the count.
- R5: On the tick that moves the count from 1, the event flag is set. With reload on, the count takes the start value. With reload off, it becomes 0 and stays there.
- R6: A write to offset 0x0 sets both the start value and the count. A write to offset 0x4 sets only the count.
- R7: A control write that turns enable from 0 to 1 with bit 1 set while the count is 0 first copies the start value into the count. Without bit 1 set, the count stays 0.
- R8: A zero count never steps and never raises the event flag, even while enabled.
- R9: A read of the count returns 0 while enable is clear or the count is zero. Otherwise it returns the remaining count.
- R10: Writing a value with bit 0 set to offset 0xC clears the event flag. Writing a value with bit 0 clear leaves it unchanged. `irq_o` always equals the flag.
- R11: If a clear write and an expiry fall on the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request, one clock per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (5) | Byte address of the access |
| acc_be | input | DATA_W/8 (4) | Byte enables; only all ones writes |
| acc_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid, one clock after a read request |
| rd_data | output | DATA_W (32) | Read data |
| irq_o | output | 1 | Level interrupt, equal to the event flag |

## Verification
The checker assumes that each access lasts one clock with `acc_en` high and that inputs are stable around the sampling edge. Both are true of a synchronous host that drives the port from registers. The properties derive count and control writes from the same address and byte-enable decode the requirements state. Stimulus that relies on an ignored write is therefore always followed by a read-back through the port. The bench drives every access half a clock away from the active edge and spaces accesses at least two clocks apart. Expiry and clear collisions are scheduled on exact edge numbers that the bench computes from the divisor and the start value.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // Word slots; the offset order is decoded by software, so it is kept fixed.
  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_COUNT = 2'd1,
    SLOT_CTRL  = 2'd2,
    SLOT_FLAG  = 2'd3
  } slot_e;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_RELOAD_BIT = 1;
  localparam int CTRL_DIV_LSB    = 8;
endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode
  import ptmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BE_W   = 4
) (
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BE_W-1:0]   acc_be,
  output logic              wr_start,
  output logic              wr_count,
  output logic              wr_ctrl,
  output logic              wr_flag,
  output logic              rd_req,
  output logic              rd_hit,
  output slot_e             rd_slot
);
  logic upper_ok;
  logic word_hit;
  logic wr_ok;
  slot_e slot;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_ok = (acc_addr[ADDR_W-1:4] == '0);
    end else begin : g_noupper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign slot     = slot_e'(acc_addr[3:2]);
  assign word_hit = upper_ok && (acc_addr[1:0] == 2'b00);
  assign wr_ok    = acc_en && acc_we && word_hit && (acc_be == {BE_W{1'b1}});

  assign wr_start = wr_ok && (slot == SLOT_START);
  assign wr_count = wr_ok && (slot == SLOT_COUNT);
  assign wr_ctrl  = wr_ok && (slot == SLOT_CTRL);
  assign wr_flag  = wr_ok && (slot == SLOT_FLAG);

  assign rd_req  = acc_en && !acc_we;
  assign rd_hit  = word_hit;
  assign rd_slot = slot;
endmodule

// File: rtl/ptmr_divider.sv
module ptmr_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  // Compare with >= so that lowering the divisor mid-period cannot strand the phase.
  assign tick = run && !restart && (phase_q >= divisor);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart || !run || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             arm,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cnt_zero = (cnt_q == '0);
  assign expire   = tick && !wr && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= wdata;
    end else if (arm) begin
      cnt_q <= start_val;
    end else if (tick && !cnt_zero) begin
      if (cnt_q == ONE) begin
        cnt_q <= reload ? start_val : '0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/ptmr_flag.sv
module ptmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= 1'b1;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W/8-1:0] acc_be,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq_o
);
  localparam int BE_W = DATA_W / 8;

  logic wr_start, wr_count, wr_ctrl, wr_flag, rd_req, rd_hit;
  slot_e rd_slot;

  logic [DATA_W-1:0] start_q;
  logic              ctrl_en_q;
  logic              ctrl_rel_q;
  logic [DIV_W-1:0]  ctrl_div_q;

  logic [DATA_W-1:0] cnt_q;
  logic              cnt_zero, expire, tick;
  logic              cnt_wr, en_rise, arm, run;
  logic              stat_q;

  logic [DATA_W-1:0] ctrl_view, cnt_view, rd_mux;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  ptmr_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .acc_en  (acc_en),
    .acc_we  (acc_we),
    .acc_addr(acc_addr),
    .acc_be  (acc_be),
    .wr_start(wr_start),
    .wr_count(wr_count),
    .wr_ctrl (wr_ctrl),
    .wr_flag (wr_flag),
    .rd_req  (rd_req),
    .rd_hit  (rd_hit),
    .rd_slot (rd_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q    <= '0;
      ctrl_en_q  <= 1'b0;
      ctrl_rel_q <= 1'b0;
      ctrl_div_q <= '0;
    end else begin
      if (wr_start) begin
        start_q <= acc_wdata;
      end
      if (wr_ctrl) begin
        ctrl_en_q  <= acc_wdata[CTRL_EN_BIT];
        ctrl_rel_q <= acc_wdata[CTRL_RELOAD_BIT];
        ctrl_div_q <= acc_wdata[CTRL_DIV_LSB +: DIV_W];
      end
    end
  end

  assign cnt_wr  = wr_start || wr_count;
  assign en_rise = wr_ctrl && acc_wdata[CTRL_EN_BIT] && !ctrl_en_q;
  assign arm     = en_rise && acc_wdata[CTRL_RELOAD_BIT] && cnt_zero;
  assign run     = ctrl_en_q && !cnt_zero;

  ptmr_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .restart(cnt_wr || en_rise),
    .divisor(ctrl_div_q),
    .tick   (tick)
  );

  ptmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .wr       (cnt_wr),
    .wdata    (acc_wdata),
    .arm      (arm),
    .start_val(start_q),
    .tick     (tick),
    .reload   (ctrl_rel_q),
    .cnt_q    (cnt_q),
    .cnt_zero (cnt_zero),
    .expire   (expire)
  );

  ptmr_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set   (expire),
    .clr   (wr_flag && acc_wdata[0]),
    .flag_q(stat_q)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN_BIT]              = ctrl_en_q;
    ctrl_view[CTRL_RELOAD_BIT]          = ctrl_rel_q;
    ctrl_view[CTRL_DIV_LSB +: DIV_W]    = ctrl_div_q;
  end

  assign cnt_view = (ctrl_en_q && !cnt_zero) ? cnt_q : '0;

  always_comb begin
    case (rd_slot)
      SLOT_START: rd_mux = start_q;
      SLOT_COUNT: rd_mux = cnt_view;
      SLOT_CTRL:  rd_mux = ctrl_view;
      default:    rd_mux = {{(DATA_W-1){1'b0}}, stat_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req;
      rd_data_q  <= (rd_req && rd_hit) ? rd_mux : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign irq_o    = stat_q;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                acc_en,
  input logic                acc_we,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic [DATA_W/8-1:0] acc_be,
  input logic                clr_bit,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data,
  input logic                irq_o,
  input logic [DATA_W-1:0]   cnt_q,
  input logic                en_q
);
  logic full_wr, cnt_wr, ctrl_wr, flag_clr, cnt_rd, rd_any;

  assign full_wr  = acc_en && acc_we && (acc_be == '1);
  assign cnt_wr   = full_wr && ((acc_addr == ADDR_W'(0)) || (acc_addr == ADDR_W'(4)));
  assign ctrl_wr  = full_wr && (acc_addr == ADDR_W'(8));
  assign flag_clr = full_wr && (acc_addr == ADDR_W'(12)) && clr_bit;
  assign rd_any   = acc_en && !acc_we;
  assign cnt_rd   = rd_any && (acc_addr == ADDR_W'(4));

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_any |=> rd_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst) !rd_any |=> !rd_valid); // R2
  AST_OFF_COUNT_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (cnt_rd && !en_q) |=> (rd_data == '0)); // R9
  AST_HOLD_WHILE_OFF: assert property (@(posedge clk) disable iff (rst) (!en_q && !cnt_wr && !ctrl_wr) |=> $stable(cnt_q)); // R4
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst) (en_q && (cnt_q > DATA_W'(1)) && !cnt_wr) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - DATA_W'(1)))); // R4
  AST_ZERO_IS_IDLE: assert property (@(posedge clk) disable iff (rst) (en_q && (cnt_q == '0) && !cnt_wr) |=> ((cnt_q == '0) && !$rose(irq_o))); // R8
  AST_FLAG_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst) $rose(irq_o) |-> $past(en_q && (cnt_q == DATA_W'(1)))); // R5
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst) (flag_clr && !(en_q && (cnt_q == DATA_W'(1)))) |=> !irq_o); // R10
endmodule

bind ptmr_top ptmr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_en  (acc_en),
  .acc_we  (acc_we),
  .acc_addr(acc_addr),
  .acc_be  (acc_be),
  .clr_bit (acc_wdata[0]),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .en_q    (ctrl_en_q)
);

// File: tb/sim_ptmr_top.sv
`timescale 1ns/1ps
module sim_ptmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptmr_top u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2 unexpected read data", rd_data, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rd_data === e.val, e.tag, rd_data, e.val);
      end
    end
  end

  task automatic idle();
    acc_en = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_be = '0; acc_wdata = '0;
  endtask

  task automatic drive_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d; acc_be = be;
  endtask

  task automatic wr_be(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    drive_wr(a, d, be);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_be(a, d, 4'hF);
  endtask

  task automatic wait_edge(input int x);
    while (cyc < x) @(negedge clk);
  endtask

  // Write that lands on active edge number x
  task automatic wr_at(input int x, input logic [4:0] a, input logic [31:0] d);
    wait_edge(x - 1);
    drive_wr(a, d, 4'hF);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a; acc_be = 4'hF;
    e.val = exp; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    idle();
  endtask

  // Count read with the expected value derived from the edge number
  task automatic rd_cnt(input int n, input int p, input int e0, input bit rel, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = 5'h04; acc_be = 4'hF;
    k = (cyc - e0) / (p + 1);
    if (rel) e.val = 32'(n - (k % n));
    else     e.val = (k >= n) ? 32'h0 : 32'(n - k);
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    idle();
  endtask

  task automatic irq_is(input bit exp, input string tag);
    chk(irq_o === exp, tag, {31'h0, irq_o}, {31'h0, exp});
  endtask

  initial begin
    int e0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    irq_is(1'b0, "R1 irq after reset");
    rd(5'h00, 32'h0, "R1 start after reset");
    rd(5'h04, 32'h0, "R1 count after reset");
    rd(5'h08, 32'h0, "R1 control after reset");
    rd(5'h0C, 32'h0, "R1 flag after reset");

    // One-shot, divisor 3, count 5
    wr(5'h00, 32'd5);
    rd(5'h00, 32'd5, "R6 start value written");
    rd(5'h04, 32'h0, "R9 count reads zero while disabled");
    wr(5'h08, 32'h0000_0301);
    e0 = cyc;
    rd_cnt(5, 3, e0, 1'b0, "R4 count right after enable");
    repeat (9) @(negedge clk);
    rd_cnt(5, 3, e0, 1'b0, "R4 count mid run");
    wait_edge(e0 + 19);
    irq_is(1'b0, "R5 no event one clock before expiry");
    wait_edge(e0 + 20);
    irq_is(1'b1, "R5 event at expiry edge");
    rd(5'h04, 32'h0, "R5 one-shot count parks at zero");
    rd(5'h0C, 32'h1, "R5 flag set");
    wr(5'h0C, 32'h0000_0002);
    rd(5'h0C, 32'h1, "R10 write with bit0 clear keeps flag");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R10 write-one clears flag");
    irq_is(1'b0, "R10 irq follows flag");
    repeat (40) @(negedge clk);
    rd(5'h0C, 32'h0, "R8 zero count raises no event");

    // Control field readback
    wr(5'h08, 32'hFFFF_FF03);
    rd(5'h08, 32'h0000_FF03, "R3 undefined control bits read zero");
    wr(5'h08, 32'h0000_0301);
    rd(5'h08, 32'h0000_0301, "R3 control readback");

    // Count-only write
    wr(5'h04, 32'd7);
    e0 = cyc;
    rd(5'h00, 32'd5, "R6 count write leaves start value");
    rd_cnt(7, 3, e0, 1'b0, "R4 countdown from count write");
    wr(5'h04, 32'h0);
    repeat (40) @(negedge clk);
    rd(5'h0C, 32'h0, "R8 enabled zero count stays idle");
    rd(5'h04, 32'h0, "R9 zero count reads zero");

    // Enable without reload from zero: no copy
    wr(5'h08, 32'h0);
    wr(5'h08, 32'h1);
    repeat (3) @(negedge clk);
    rd(5'h04, 32'h0, "R7 no copy without reload bit");
    wr(5'h08, 32'h0);

    // Periodic, divisor 1, enable from zero copies start value
    wr(5'h08, 32'h0000_0103);
    e0 = cyc;
    rd_cnt(5, 1, e0, 1'b1, "R7 start value copied on enable");
    wait_edge(e0 + 9);
    irq_is(1'b0, "R5 periodic before first expiry");
    wait_edge(e0 + 10);
    irq_is(1'b1, "R5 periodic first expiry");
    rd_cnt(5, 1, e0, 1'b1, "R5 count refilled and running");
    wr_at(e0 + 20, 5'h0C, 32'h1);
    rd(5'h0C, 32'h1, "R11 expiry wins over clear");
    wr(5'h0C, 32'h1);
    rd(5'h0C, 32'h0, "R10 clear in periodic mode");
    wr(5'h00, 32'd9);
    e0 = cyc;
    repeat (3) @(negedge clk);
    rd_cnt(9, 1, e0, 1'b1, "R6 start write restarts countdown");

    // Ignored writes and unmapped reads
    wr(5'h10, 32'hAB);
    wr(5'h01, 32'h99);
    wr_be(5'h00, 32'h77, 4'h3);
    rd(5'h00, 32'd9, "R2 ignored writes leave start value");
    rd(5'h10, 32'h0, "R2 unmapped offset reads zero");
    rd(5'h02, 32'h0, "R2 misaligned read returns zero");
    rd(5'h08, 32'h0000_0103, "R2 control untouched by ignored writes");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R2 all reads answered", 32'(sbq.size()), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule